// File: doc/BRIEF.md
# Carry-Absorbing Add Execution Slice

This block executes one fixed-point operation: it adds the carry flag held in a status register to a 32-bit source register, with zero as the second operand, and writes the sum to a target register. The issue port carries two flags. The overflow-enable flag controls whether the overflow and sticky summary-overflow flags are updated. The record flag controls whether a 4-bit condition field is rewritten. The carry flag is refreshed by every issued operation. Everything commits on the clock edge that samples a valid issue, so the slice takes one cycle per operation and has no pipeline.

A test port can load any register-file entry, read any entry back, and overwrite the status register. The bench uses it to set up operands and to observe results. When an issue and a test write arrive in the same cycle, the issue has priority.

Top module: `zext_unit`

## Requirements
- R1: When `iss_valid` is 1 at a rising edge, register `iss_dst` takes the value (register `iss_src` + status carry) mod 2^32 at that edge. When `iss_valid` is 0, no register changes because of the issue port.
- R2: Every valid issue sets the carry flag, status bit 0, to the carry-out of that 33-bit sum, whatever the values of the two flags.
- R3: With `iss_oe`=0, the overflow flag (status bit 1) and the summary-overflow flag (status bit 2) keep their values across the issue.
- R4: With `iss_oe`=1, the overflow flag becomes 1 exactly when the source is non-negative and the result is negative. The summary-overflow flag becomes its old value ORed with the new overflow flag, so it is sticky.
- R5: With `iss_rc`=1, `cr0_q` is rewritten. Bit 3 is result<0 (signed), bit 2 is result>0, bit 1 is result==0, and bit 0 is the summary-overflow flag as it stands after this issue's own status update.
- R6: With `iss_rc`=0, `cr0_q` keeps its value across the issue.
- R7: Synchronous active-high reset clears all 32 registers, the status register and `cr0_q` to zero.
- R8: The test port writes register `tp_rf_idx` with `tp_rf_wdata`, and the status register with `tp_st_wdata` (bit 2 summary overflow, bit 1 overflow, bit 0 carry). Each write is taken only in a cycle with `iss_valid`=0 and is dropped when an issue is present in that cycle.
- R9: `tp_rf_rdata` shows register `tp_rf_ridx` combinationally, and `st_q` shows the status register with the bit layout of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue qualifier |
| iss_src | input | 5 | Source register index |
| iss_dst | input | 5 | Target register index |
| iss_oe | input | 1 | Overflow-enable flag |
| iss_rc | input | 1 | Record flag |
| tp_rf_we | input | 1 | Test write enable for the register file |
| tp_rf_idx | input | 5 | Test write index |
| tp_rf_wdata | input | 32 | Test write data |
| tp_rf_ridx | input | 5 | Test read index |
| tp_rf_rdata | output | 32 | Test read data |
| tp_st_we | input | 1 | Test write enable for the status register |
| tp_st_wdata | input | 3 | Status write value {SO, OV, CA} |
| st_q | output | 3 | Status register {SO, OV, CA} |
| cr0_q | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The hardest case to reach from the ports is the interaction of the sticky summary-overflow flag with the record flag. It needs a known prior summary value, an operation that does or does not overflow, and both flag combinations. The bench reaches it by preloading the status register through the test port before each issue. It sweeps boundary operands (0x7FFFFFFF, 0xFFFFFFFF, 0x80000000, zero) across every carry, prior-SO, overflow-enable and record combination. A further case collides an issue with test-port writes to the same target in the same cycle.

// File: rtl/zext_pkg.sv
package zext_pkg;

    // Status register layout: bit2 summary overflow, bit1 overflow, bit0 carry
    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } xstat_t;

    // Condition field layout: bit3 LT, bit2 GT, bit1 EQ, bit0 SO
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cfield_t;

    function automatic xstat_t next_stat(xstat_t cur, logic cout, logic ovf, logic oe);
        xstat_t n;
        n.ca = cout;
        n.ov = oe ? ovf : cur.ov;
        n.so = oe ? (cur.so | ovf) : cur.so;
        return n;
    endfunction

    function automatic cfield_t make_cfield(logic neg, logic zero, logic so);
        cfield_t c;
        c.lt = neg;
        c.gt = ~neg & ~zero;
        c.eq = zero;
        c.so = so;
        return c;
    endfunction

endpackage

// File: rtl/zext_adder.sv
module zext_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf,
    output logic         neg,
    output logic         zero
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = ~a[W-1] & wide[W-1];
        neg  = wide[W-1];
        zero = (wide[W-1:0] == '0);
    end
endmodule

// File: rtl/zext_regfile.sv
module zext_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && wa == IW'(g))
                regs[g] <= wd;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

    // R1 / R8: a granted write is visible on the read port one edge later
    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(wa)] == $past(wd));
endmodule

// File: rtl/zext_status.sv
module zext_status
    import zext_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    upd,
    input  logic    oe,
    input  logic    rec,
    input  logic    cout,
    input  logic    ovf,
    input  logic    neg,
    input  logic    zero,
    input  logic    tw_en,
    input  xstat_t  tw_data,
    output xstat_t  stat,
    output cfield_t cf
);
    xstat_t stat_nx;

    always_comb stat_nx = next_stat(stat, cout, ovf, oe);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            cf   <= '0;
        end else if (upd) begin
            stat <= stat_nx;
            if (rec)
                cf <= make_cfield(neg, zero, stat_nx.so);
        end else if (tw_en) begin
            stat <= tw_data;
        end
    end

    a_r2_carry_follows: assert property (@(posedge clk) disable iff (rst)
        upd |=> stat.ca == $past(cout));
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        upd && !oe |=> stat.ov == $past(stat.ov) && stat.so == $past(stat.so));
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        upd && oe && stat.so |=> stat.so);
    a_r4_ov_value: assert property (@(posedge clk) disable iff (rst)
        upd && oe |=> stat.ov == $past(ovf));
    a_r5_one_sign: assert property (@(posedge clk) disable iff (rst)
        upd && rec |=> $countones({cf.lt, cf.gt, cf.eq}) == 1);
    a_r5_so_copy: assert property (@(posedge clk) disable iff (rst)
        upd && rec |=> cf.so == stat.so);
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        upd && !rec |=> $stable(cf));
    a_r8_test_write: assert property (@(posedge clk) disable iff (rst)
        !upd && tw_en |=> stat == $past(tw_data));
endmodule

// File: rtl/zext_unit.sv
module zext_unit
    import zext_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_valid,
    input  logic [IW-1:0]   iss_src,
    input  logic [IW-1:0]   iss_dst,
    input  logic            iss_oe,
    input  logic            iss_rc,
    input  logic            tp_rf_we,
    input  logic [IW-1:0]   tp_rf_idx,
    input  logic [XLEN-1:0] tp_rf_wdata,
    input  logic [IW-1:0]   tp_rf_ridx,
    output logic [XLEN-1:0] tp_rf_rdata,
    input  logic            tp_st_we,
    input  logic [2:0]      tp_st_wdata,
    output logic [2:0]      st_q,
    output logic [3:0]      cr0_q
);
    logic [XLEN-1:0] src_val, sum;
    logic            cout, ovf, neg, zero;
    logic            wr_en;
    logic [IW-1:0]   wr_idx;
    logic [XLEN-1:0] wr_data;
    xstat_t          stat;
    cfield_t         cf;

    always_comb begin
        wr_en   = iss_valid | tp_rf_we;
        wr_idx  = iss_valid ? iss_dst : tp_rf_idx;
        wr_data = iss_valid ? sum : tp_rf_wdata;
    end

    zext_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .ra_idx(iss_src), .ra_data(src_val),
        .rb_idx(tp_rf_ridx), .rb_data(tp_rf_rdata),
        .we(wr_en), .wa(wr_idx), .wd(wr_data)
    );

    zext_adder #(.W(XLEN)) u_add (
        .a(src_val), .cin(stat.ca), .sum(sum),
        .cout(cout), .ovf(ovf), .neg(neg), .zero(zero)
    );

    zext_status u_st (
        .clk(clk), .rst(rst), .upd(iss_valid), .oe(iss_oe), .rec(iss_rc),
        .cout(cout), .ovf(ovf), .neg(neg), .zero(zero),
        .tw_en(tp_st_we), .tw_data(xstat_t'(tp_st_wdata)),
        .stat(stat), .cf(cf)
    );

    assign st_q  = stat;
    assign cr0_q = cf;

    // R1: a non-overflowing issue result is one more than or equal to its source
    a_r1_sum_range: assert property (@(posedge clk) disable iff (rst)
        iss_valid && !cout |-> (sum - src_val) <= XLEN'(1));
endmodule

// File: tb/sim_zext_unit.sv
module sim_zext_unit;
    logic        clk = 0;
    logic        rst = 1;
    logic        iss_valid = 0, iss_oe = 0, iss_rc = 0;
    logic [4:0]  iss_src = 0, iss_dst = 0;
    logic        tp_rf_we = 0, tp_st_we = 0;
    logic [4:0]  tp_rf_idx = 0, tp_rf_ridx = 0;
    logic [31:0] tp_rf_wdata = 0, tp_rf_rdata;
    logic [2:0]  tp_st_wdata = 0, st_q;
    logic [3:0]  cr0_q;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [3:0] cr_model = 0;

    always #10 clk = ~clk;

    zext_unit u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] v);
        tp_rf_ridx = idx;
        #1 v = tp_rf_rdata;
    endtask

    task automatic run_op(logic [31:0] val, logic cin, logic oe, logic rc,
                          logic so0, logic ov0, logic [4:0] s, logic [4:0] d);
        logic [32:0] w;
        logic [31:0] r, got;
        logic ovf, so_n, ov_n;
        @(negedge clk);
        tp_rf_we = 1; tp_rf_idx = s; tp_rf_wdata = val;
        tp_st_we = 1; tp_st_wdata = {so0, ov0, cin};
        @(negedge clk);
        tp_rf_we = 0; tp_st_we = 0;
        iss_valid = 1; iss_src = s; iss_dst = d; iss_oe = oe; iss_rc = rc;
        @(negedge clk);
        iss_valid = 0;
        w = {1'b0, val} + 33'(cin);
        r = w[31:0];
        ovf = !val[31] && r[31];
        ov_n = oe ? ovf : ov0;
        so_n = oe ? (so0 | ovf) : so0;
        if (rc) cr_model = {r[31], !r[31] && r != 0, r == 0, so_n};
        rd(d, got);
        chk("R1 result", got, r);
        chk("R2 carry", 32'(st_q[0]), 32'(w[32]));
        if (oe) chk("R4 ov/so", 32'(st_q[2:1]), 32'({so_n, ov_n}));
        else    chk("R3 ov/so held", 32'(st_q[2:1]), 32'({so0, ov0}));
        if (rc) chk("R5 cond", 32'(cr0_q), 32'(cr_model));
        else    chk("R6 cond held", 32'(cr0_q), 32'(cr_model));
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] vals [8] = '{32'hEFFFFFFF, 32'h90003000, 32'h7B4192C0, 32'h7FFFFFFF,
                                  32'hFFFFFFFF, 32'h00000000, 32'h80000000, 32'h00000001};
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R7 reset state
        chk("R7 status", 32'(st_q), 0);
        chk("R7 cond", 32'(cr0_q), 0);
        for (int k = 0; k < 32; k += 9) begin rd(5'(k), v); chk("R7 reg", v, 0); end
        // R9 status read and R1 idle: no issue leaves registers alone
        @(negedge clk); tp_st_we = 1; tp_st_wdata = 3'b101;
        @(negedge clk); tp_st_we = 0;
        chk("R9 status layout", 32'(st_q), 32'h5);
        rd(5'd3, v); chk("R1 idle no write", v, 0);
        // near-exhaustive sweep
        for (int i = 0; i < 128; i++) begin
            run_op(vals[i % 8], i[3], i[4], i[5], i[6], i[0] ^ i[6],
                   5'(i % 32), 5'((i * 7 + 3) % 32));
        end
        // R8: same-cycle collision, issue wins; then prior value remains
        @(negedge clk);
        tp_rf_we = 1; tp_rf_idx = 5'd10; tp_rf_wdata = 32'h00000041;
        tp_st_we = 1; tp_st_wdata = 3'b001;
        @(negedge clk);
        tp_rf_we = 0; tp_st_we = 0;
        iss_valid = 1; iss_src = 5'd10; iss_dst = 5'd11; iss_oe = 0; iss_rc = 0;
        tp_rf_we = 1; tp_rf_idx = 5'd11; tp_rf_wdata = 32'hDEADBEEF;
        tp_st_we = 1; tp_st_wdata = 3'b110;
        @(negedge clk);
        iss_valid = 0; tp_rf_we = 0; tp_st_we = 0;
        rd(5'd11, v);
        chk("R8 issue beats rf test write", v, 32'h00000042);
        chk("R8 status test write dropped", 32'(st_q), 32'h0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule